// File: doc/BRIEF.md
# Linked Display Node Fetcher

This block is the setup front end of one graphics layer in a display compositor. The layer is not set up through registers. It takes its settings from descriptor nodes kept in memory. Each node holds sixteen 32-bit words, and one of those words is the address of the next node. At a vertical sync the block reads the node that its pointer register addresses, one word per request, over a valid/ready read port. It holds the words in a shadow set. Once the whole node is in, it moves the pointer on to the node's next-node word and publishes the layer parameters on its outputs.

The usual arrangement is two nodes that point at each other. One describes the top field and the other the bottom field, so the layer alternates between them on successive syncs. In interlaced use the bottom node's pixel address is the top node's address plus one pitch. Software can also overwrite the pointer through a one-word write port to redirect the chain. A node can be made to wait for the next sync before it takes effect. Otherwise it is applied as soon as its fetch ends.

Back-pressure rules. A request is held, with a fixed address, until the memory side raises ready. Only one request is outstanding at a time. The response port is ready only while that request waits for its data, and a response is taken in the cycle in which it is valid and ready.

Top module: `ldn_fetch_top`

## Requirements
- R1: After reset, layer_skip is 1, every other layer output is 0, field_bot is 0 (top field), and no memory request is made.
- R2: A vsync that arrives while the block is idle and the pointer is non-zero starts a fetch. The fetch reads word offsets 0..15 in order, at the pointer with address bits [3:0] cleared plus 4 times the word index.
- R3: A vsync that arrives while the pointer is zero starts no fetch.
- R4: At the end of a fetch the pointer takes word 9 (the next-node address) of the fetched node, so nodes that point at each other are used in turn on successive syncs.
- R5: If bit 31 of word 0 of a fetched node is 0, the node is applied in the cycle after its last word arrives. If bit 31 is 1, the node is applied at the next vsync instead. Layer outputs change at no other time.
- R6: fmt is word 0 bits [4:0], and alpha_full is word 0 bit 5. src_h is word 7 bits [26:16] and src_w is word 7 bits [10:0].
- R7: org_line and org_pix are word 3 bits [31:16] and [15:0]. end_line and end_pix are word 4 bits [31:16] and [15:0]. pix_base is word 5 and pix_pitch is word 6.
- R8: layer_skip is 1 when either of bits [1:0] of word 13 is set, and 0 otherwise.
- R9: A pointer write made while the block is idle takes effect at once. A pointer write made during a fetch does not change the words being loaded, and at the end of the fetch it replaces the node's next-node address as the new pointer.
- R10: field_bot toggles on every vsync.
- R11: A vsync that arrives during a fetch, including the fetch's final cycle, starts nothing and applies nothing. Its only effect is to toggle the field.
- R12: mem_req_valid stays high with a fixed address until it is accepted, and no new request is made while a response is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| vsync | input | 1 | one-cycle vertical sync pulse |
| ptr_wr | input | 1 | write strobe for the next-node pointer |
| ptr_wdata | input | ADDR_W | new pointer value |
| mem_req_valid | output | 1 | read request valid |
| mem_req_ready | input | 1 | memory accepts the request |
| mem_req_addr | output | ADDR_W | byte address of the word requested |
| mem_rsp_valid | input | 1 | read data valid |
| mem_rsp_ready | output | 1 | block awaits read data |
| mem_rsp_data | input | 32 | read data |
| fmt | output | 5 | pixel format code |
| alpha_full | output | 1 | alpha range 0..255 selected |
| src_w | output | 11 | source width |
| src_h | output | 11 | source height |
| org_line | output | 16 | viewport first line |
| org_pix | output | 16 | viewport first pixel |
| end_line | output | 16 | viewport last line |
| end_pix | output | 16 | viewport last pixel |
| pix_base | output | 32 | pixel memory base address |
| pix_pitch | output | 32 | line pitch in bytes |
| layer_skip | output | 1 | layer to be ignored by the mixer |
| field_bot | output | 1 | 1 while the current field is the bottom field |

## Verification
The assertions assume that vsync is a single-cycle pulse and that the memory side raises mem_rsp_valid only after it has accepted a request. They also assume that the memory side keeps mem_rsp_valid and its data steady until the response is taken. The bench's responder follows these rules: it answers only a captured request, after a delay of zero to two cycles, and it drops valid once the handshake is done. It varies mem_req_ready in a repeating pattern, so some requests wait and others are taken at once. Vsync pulses and pointer writes are placed both in idle gaps and in the middle of fetches.

// File: rtl/ldn_pkg.sv
package ldn_pkg;
  localparam int NODE_WORDS = 16;
  localparam int WORD_W     = 32;
  localparam int W_CTRL = 0;
  localparam int W_ORG  = 3;
  localparam int W_END  = 4;
  localparam int W_BASE = 5;
  localparam int W_PTCH = 6;
  localparam int W_SIZE = 7;
  localparam int W_LINK = 9;
  localparam int W_FLAG = 13;
  localparam int CTRL_DEFER_BIT = 31;
  localparam int CTRL_ALPHA_BIT = 5;

  typedef logic [NODE_WORDS-1:0][WORD_W-1:0] node_t;

  typedef struct packed {
    logic [4:0]  fmt;
    logic        alpha_full;
    logic [10:0] w;
    logic [10:0] h;
    logic [15:0] org_line;
    logic [15:0] org_pix;
    logic [15:0] end_line;
    logic [15:0] end_pix;
    logic [31:0] base;
    logic [31:0] pitch;
    logic        skip;
  } layer_t;

  localparam layer_t LAYER_RST = '{fmt: '0, alpha_full: 1'b0, w: '0, h: '0,
                                   org_line: '0, org_pix: '0, end_line: '0,
                                   end_pix: '0, base: '0, pitch: '0, skip: 1'b1};

  function automatic layer_t decode_node(input node_t n);
    layer_t l;
    l.fmt        = n[W_CTRL][4:0];
    l.alpha_full = n[W_CTRL][CTRL_ALPHA_BIT];
    l.h          = n[W_SIZE][26:16];
    l.w          = n[W_SIZE][10:0];
    l.org_line   = n[W_ORG][31:16];
    l.org_pix    = n[W_ORG][15:0];
    l.end_line   = n[W_END][31:16];
    l.end_pix    = n[W_END][15:0];
    l.base       = n[W_BASE];
    l.pitch      = n[W_PTCH];
    l.skip       = |n[W_FLAG][1:0];
    return l;
  endfunction
endpackage

// File: rtl/ldn_word_seq.sv
module ldn_word_seq #(
  parameter int ADDR_W = 32,
  parameter int NW     = 16,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  output logic              wr_en,
  output logic [$clog2(NW)-1:0] wr_idx,
  output logic              busy,
  output logic              done
);
  localparam int IDXW = $clog2(NW);
  localparam logic [IDXW-1:0] LAST = IDXW'(NW - 1);

  logic [IDXW-1:0]   idx;
  logic [ADDR_W-1:0] base;
  logic              outst;

  assign req_valid = busy && !outst;
  assign rsp_ready = outst;
  assign wr_en     = outst && rsp_valid;
  assign wr_idx    = idx;
  assign req_addr  = base + ADDR_W'({idx, 2'b00});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      outst <= 1'b0;
      idx   <= '0;
      base  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        idx   <= '0;
        outst <= 1'b0;
        base  <= start_base;
      end else if (busy) begin
        if (req_valid && req_ready) outst <= 1'b1;
        if (wr_en) begin
          outst <= 1'b0;
          if (idx == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ldn_shadow.sv
module ldn_shadow #(
  parameter int NW = 16,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [$clog2(NW)-1:0] wr_idx,
  input  logic [DW-1:0]        wr_data,
  output logic [NW-1:0][DW-1:0] words
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   words[g] <= '0;
      else if (wr_en && wr_idx == $clog2(NW)'(g))   words[g] <= wr_data;
    end
  end
endmodule

// File: rtl/ldn_active.sv
module ldn_active
  import ldn_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   vsync,
  input  logic   load,
  input  layer_t nxt,
  output layer_t act,
  output logic   field_bot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act       <= LAYER_RST;
      field_bot <= 1'b0;
    end else begin
      if (vsync) field_bot <= ~field_bot;
      if (load)  act       <= nxt;
    end
  end
endmodule

// File: rtl/ldn_fetch_top.sv
module ldn_fetch_top
  import ldn_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              ptr_wr,
  input  logic [ADDR_W-1:0] ptr_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [31:0]       mem_rsp_data,
  output logic [4:0]        fmt,
  output logic              alpha_full,
  output logic [10:0]       src_w,
  output logic [10:0]       src_h,
  output logic [15:0]       org_line,
  output logic [15:0]       org_pix,
  output logic [15:0]       end_line,
  output logic [15:0]       end_pix,
  output logic [31:0]       pix_base,
  output logic [31:0]       pix_pitch,
  output logic              layer_skip,
  output logic              field_bot
);
  localparam int NW   = NODE_WORDS;
  localparam int IDXW = $clog2(NW);

  logic              busy, done_w, idle, start, ptr_is_zero;
  logic              wr_en, pend, hold_v, load;
  logic [IDXW-1:0]   wr_idx;
  logic [ADDR_W-1:0] ptr, hold, base;
  node_t             words;
  layer_t            act;

  assign idle        = !busy && !done_w;
  assign ptr_is_zero = (ptr == '0);
  assign start       = vsync && idle && !ptr_is_zero;
  assign base        = {ptr[ADDR_W-1:4], 4'b0000};
  assign load        = (done_w && !words[W_CTRL][CTRL_DEFER_BIT]) || (vsync && idle && pend);

  ldn_word_seq #(.ADDR_W(ADDR_W), .NW(NW), .DW(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(base),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
    .rsp_valid(mem_rsp_valid), .rsp_ready(mem_rsp_ready),
    .wr_en(wr_en), .wr_idx(wr_idx), .busy(busy), .done(done_w));

  ldn_shadow #(.NW(NW), .DW(WORD_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(mem_rsp_data), .words(words));

  ldn_active u_act (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .load(load),
    .nxt(decode_node(words)), .act(act), .field_bot(field_bot));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      hold   <= '0;
      hold_v <= 1'b0;
      pend   <= 1'b0;
    end else if (done_w) begin
      ptr    <= ptr_wr ? ptr_wdata : (hold_v ? hold : words[W_LINK][ADDR_W-1:0]);
      hold_v <= 1'b0;
      pend   <= words[W_CTRL][CTRL_DEFER_BIT];
    end else begin
      if (ptr_wr) begin
        if (busy) begin
          hold   <= ptr_wdata;
          hold_v <= 1'b1;
        end else begin
          ptr <= ptr_wdata;
        end
      end
      if (vsync && idle) pend <= 1'b0;
    end
  end

  assign fmt        = act.fmt;
  assign alpha_full = act.alpha_full;
  assign src_w      = act.w;
  assign src_h      = act.h;
  assign org_line   = act.org_line;
  assign org_pix    = act.org_pix;
  assign end_line   = act.end_line;
  assign end_pix    = act.end_pix;
  assign pix_base   = act.base;
  assign pix_pitch  = act.pitch;
  assign layer_skip = act.skip;
endmodule

// File: rtl/ldn_checker.sv
module ldn_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vsync,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_ready,
  input logic              field_bot,
  input logic [31:0]       pix_base,
  input logic              fetch_done,
  input logic              idle,
  input logic              ptr_zero
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !rsp_ready);

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[1:0] == 2'b00);

  assert_no_fetch_on_null_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vsync && idle && ptr_zero |=> !req_valid);

  assert_field_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> field_bot != $past(field_bot));

  assert_field_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(field_bot));

  assert_quiet_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync && !fetch_done |=> $stable(pix_base));
endmodule

bind ldn_fetch_top ldn_checker #(.ADDR_W(ADDR_W)) u_ldn_chk (
  .clk(clk), .rst_n(rst_n), .vsync(vsync),
  .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
  .rsp_ready(mem_rsp_ready), .field_bot(field_bot), .pix_base(pix_base),
  .fetch_done(done_w), .idle(idle), .ptr_zero(ptr_is_zero));

// File: tb/test_ldn_fetch_top.sv
module test_ldn_fetch_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vsync = 1'b0, ptr_wr = 1'b0;
  logic [31:0] ptr_wdata = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [31:0] mem_req_addr, mem_rsp_data = '0;
  logic [4:0]  fmt;
  logic        alpha_full, layer_skip, field_bot;
  logic [10:0] src_w, src_h;
  logic [15:0] org_line, org_pix, end_line, end_pix;
  logic [31:0] pix_base, pix_pitch;

  ldn_fetch_top i_ldn_fetch_top (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  logic [31:0] mem [0:127];

  // reference model state
  bit          m_busy, m_outst, m_done, m_pend, m_holdv, m_field;
  int          m_cnt;
  logic [31:0] m_base, m_ptr, m_hold;
  logic [31:0] sh [16];
  logic [31:0] e_ctrl, e_org, e_end, e_base, e_pitch, e_size, e_flag;
  // responder and stimulus
  bit          r_have, vs_next, wr_next;
  logic [31:0] r_addr, wd_next;
  int          r_delay, pat;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_node();
    e_ctrl = sh[0]; e_org = sh[3]; e_end = sh[4]; e_base = sh[5];
    e_pitch = sh[6]; e_size = sh[7]; e_flag = sh[13];
  endtask

  task automatic model_reset();
    m_busy = 0; m_outst = 0; m_done = 0; m_pend = 0; m_holdv = 0; m_field = 0;
    m_cnt = 0; m_base = '0; m_ptr = '0; m_hold = '0;
    for (int i = 0; i < 16; i++) sh[i] = '0;
    e_ctrl = '0; e_org = '0; e_end = '0; e_base = '0; e_pitch = '0; e_size = '0;
    e_flag = 32'h1;  // reset state is the ignored layer
    r_have = 0;
  endtask

  task automatic compare_all();
    chk("R6 fmt", 32'(fmt), 32'(e_ctrl[4:0]));
    chk("R6 alpha_full", 32'(alpha_full), 32'(e_ctrl[5]));
    chk("R6 src_h", 32'(src_h), 32'(e_size[26:16]));
    chk("R6 src_w", 32'(src_w), 32'(e_size[10:0]));
    chk("R7 org", {org_line, org_pix}, e_org);
    chk("R7 end", {end_line, end_pix}, e_end);
    chk("R7 pix_base", pix_base, e_base);
    chk("R7 pix_pitch", pix_pitch, e_pitch);
    chk("R8 layer_skip", 32'(layer_skip), 32'(|e_flag[1:0]));
    chk("R10 field_bot", 32'(field_bot), 32'(m_field));
    chk("R2 req_valid", 32'(mem_req_valid), 32'(m_busy && !m_outst));
    chk("R12 rsp_ready", 32'(mem_rsp_ready), 32'(m_outst));
    if (mem_req_valid) chk("R2 req_addr", mem_req_addr, m_base + 32'(4 * m_cnt));
  endtask

  task automatic step();
    bit req_hs, rsp_hs, was_idle, prev_done;
    logic [31:0] old_ptr;
    @(negedge clk);
    if (rst_n) compare_all();
    vsync = vs_next; ptr_wr = wr_next; ptr_wdata = wd_next;
    vs_next = 0; wr_next = 0;
    pat++;
    mem_req_ready = (pat % 3) != 1;
    mem_rsp_valid = 1'b0;
    if (r_have) begin
      if (r_delay == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem[r_addr[8:2]];
      end else r_delay--;
    end
    #1;
    req_hs = mem_req_valid && mem_req_ready;
    rsp_hs = mem_rsp_valid && mem_rsp_ready;
    if (!rst_n) model_reset();
    else begin
      was_idle = !m_busy && !m_done;
      prev_done = m_done;
      old_ptr = m_ptr;
      m_done = 0;
      if (vsync) m_field = !m_field;
      if (vsync && was_idle) begin
        if (m_pend) apply_node();
        m_pend = 0;
        if (old_ptr != 0) begin
          m_busy = 1; m_cnt = 0; m_outst = 0; m_base = old_ptr & 32'hFFFF_FFF0;
        end
      end
      if (req_hs) m_outst = 1;
      if (rsp_hs) begin
        sh[m_cnt] = mem_rsp_data;
        m_outst = 0;
        if (m_cnt == 15) begin m_busy = 0; m_done = 1; end
        else m_cnt++;
      end
      if (prev_done) begin
        m_ptr = ptr_wr ? ptr_wdata : (m_holdv ? m_hold : sh[9]);
        m_holdv = 0;
        if (sh[0][31]) m_pend = 1; else apply_node();
      end else if (ptr_wr) begin
        if (!was_idle) begin m_hold = ptr_wdata; m_holdv = 1; end
        else m_ptr = ptr_wdata;
      end
    end
    if (rsp_hs) r_have = 0;
    if (req_hs) begin r_have = 1; r_addr = mem_req_addr; r_delay = pat % 3; end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic pulse_vs();
    vs_next = 1; step();
  endtask
  task automatic cpu_write(logic [31:0] v);
    wr_next = 1; wd_next = v; step();
  endtask

  task automatic set_node(int b, logic [31:0] ctrl, logic [31:0] link,
                          logic [31:0] pml, logic [31:0] flag);
    mem[b/4 + 0]  = ctrl;
    mem[b/4 + 3]  = {16'(b), 16'h0020};
    mem[b/4 + 4]  = {16'(b + 16'h0100), 16'h02D0};
    mem[b/4 + 5]  = pml;
    mem[b/4 + 6]  = 32'h0000_0780;
    mem[b/4 + 7]  = 32'hF8A3_F9C6 ^ 32'(b);
    mem[b/4 + 9]  = link;
    mem[b/4 + 13] = flag;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h5A00_0000 | 32'(i * 32'h0101);
    set_node(32'h40,  32'h8000_0025, 32'h80,  32'h1000_0000, 32'h0);
    set_node(32'h80,  32'h8000_0025, 32'h40,  32'h1000_0780, 32'h0);
    set_node(32'hC0,  32'h0000_000B, 32'h0,   32'h2000_0000, 32'h3);
    set_node(32'h100, 32'h0000_0015, 32'h100, 32'h3000_0000, 32'hFFFF_FFFC);
    model_reset();
    run(3);
    rst_n = 1'b1;
    run(2);
    chk("R1 skip after reset", 32'(layer_skip), 32'h1);
    chk("R1 base after reset", pix_base, 32'h0);
    chk("R1 field top", 32'(field_bot), 32'h0);
    chk("R1 no request", 32'(mem_req_valid), 32'h0);
    pulse_vs(); run(5);
    chk("R3 null pointer no fetch", 32'(mem_req_valid), 32'h0);
    chk("R10 field toggled", 32'(field_bot), 32'h1);
    cpu_write(32'h4B); pulse_vs(); run(1);
    chk("R9 idle write used, R2 low bits cleared", mem_req_addr, 32'h40);
    run(150);
    chk("R5 deferred node not applied yet", pix_base, 32'h0);
    pulse_vs(); run(1);
    chk("R5 deferred node applied at vsync", pix_base, 32'h1000_0000);
    chk("R6 format", 32'(fmt), 32'h05);
    chk("R6 alpha range", 32'(alpha_full), 32'h1);
    run(150); pulse_vs(); run(1);
    chk("R4 chain reached bottom node", pix_base, 32'h1000_0780);
    run(150);
    pulse_vs(); run(1);
    chk("R4 chain back to top node", pix_base, 32'h1000_0000);
    run(10); cpu_write(32'hC0); pulse_vs(); run(150);
    chk("R11 mid-fetch vsync applied nothing", pix_base, 32'h1000_0000);
    pulse_vs(); run(1);
    chk("R9 loaded node intact", pix_base, 32'h1000_0780);
    run(150);
    chk("R5 immediate node applied", pix_base, 32'h2000_0000);
    chk("R8 skip from flags", 32'(layer_skip), 32'h1);
    chk("R6 clut format", 32'(fmt), 32'h0B);
    pulse_vs(); run(5);
    chk("R3 chain end stops fetch", 32'(mem_req_valid), 32'h0);
    cpu_write(32'h100); pulse_vs(); run(150);
    chk("R8 flags clear", 32'(layer_skip), 32'h0);
    for (int k = 0; k < 8; k++) begin
      pulse_vs(); run(20 + k * 13);
      if (k == 3) cpu_write(32'h40);
    end
    run(200);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule